// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time in packed BCD counters for seconds, minutes, hours, day of month, month, two-digit year and weekday. A 1 Hz tick input advances the time by one second while a control bit lets it run. Software reaches the counters and the control register through a byte-wide register port. Writes land on the next clock edge, and reads are combinational from the address. A snapshot bit freezes a copy of the time, so that a multi-byte read sees one consistent instant even if a tick arrives while it is under way.

The hours counter works in either 24-hour or 12-hour format. In the 12-hour format bit 7 of the hours byte is the PM flag. The day-of-month counter follows the length of each month and treats every two-digit year divisible by four as a leap year. One-cycle event pulses mark each second step and the minute, hour and day rollovers. A round request snaps the seconds to the nearest minute on the next counted tick.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00 with day 0x01, month 0x01, year 0x00 and weekday 0x00. The control register reads 0x00 (clock stopped, 24-hour format) and all event outputs are low.
- R2: The register map is seconds 0x00, minutes 0x01, hours 0x02, day 0x03, month 0x04, year 0x05, weekday 0x06 and control 0x0D. Every time field is written and read back as packed BCD. Any other address reads 0x00.
- R3: While control bit 0 is 1, each cycle with the tick input high advances the seconds by one and raises the second event in the following cycle. While bit 0 is 0, ticks change no counter and raise no event.
- R4: Seconds roll 0x59 to 0x00 and raise the minute event. Minutes roll 0x59 to 0x00 and raise the hour event. In the 24-hour format (control bit 3 = 0) hours roll 0x23 to 0x00 and raise the day event. Each event is accompanied by all the events of smaller units.
- R5: With control bit 3 = 1 (12-hour format) the hours field counts 0x12, 0x01 … 0x11 in bits 4:0. Going from 11 to 12 toggles the PM flag in bit 7. Going from 11 PM (0x91) to 12 AM (0x12) raises the day event.
- R6: On a day rollover the day returns to 0x01 after the last day of the month: 30 days for months 0x04, 0x06, 0x09 and 0x11, and 31 days for the other months except February. Month 0x12 rolls to 0x01 and advances the year, and year 0x99 rolls to 0x00.
- R7: February has 0x29 days when the year, read as a decimal value, is divisible by 4 (year 0x00 included), and 0x28 days otherwise.
- R8: The weekday counts 0x00 to 0x06, advances by one on every day rollover and wraps from 0x06 to 0x00.
- R9: A control write with bit 6 set captures all seven time fields. While bit 6 reads 1, reads of addresses 0x00 to 0x06 return the captured values as the live counters keep running. A control write with bit 6 clear returns the reads to the live counters.
- R10: While control bit 1 is set, the next counted tick sets seconds to 0x00 instead of incrementing them. If the seconds were 0x30 or more, that tick also counts as a minute rollover. Bit 1 then clears itself, and bit 2 is stored and read back with no effect on counting.
- R11: A write to a time register takes effect at the next clock edge. If a tick arrives in the same cycle as that write, the write wins, the tick is dropped and no event is raised. A value written while the clock is stopped stays until counting resumes.
- R12: Each event output is a registered pulse one cycle wide for each counted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_1hz_i | input | 1 | One-cycle pulse once per second |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational from addr_i) |
| sec_evt_o | output | 1 | Pulse on each counted second |
| min_evt_o | output | 1 | Pulse on minute rollover |
| hour_evt_o | output | 1 | Pulse on hour rollover |
| day_evt_o | output | 1 | Pulse on day rollover |

## Verification
The bench drives the full cascade from 23:59:59 on 31 December of year 99. A design that misses a carry would leave some field unwrapped and an event low. Month ends are tested for 30-day months, for February in a leap and a non-leap year, and for the year 00. A wrong leap rule or an off-by-one month length would land on the wrong day. The 12-hour tests cover the 11 AM to 12 PM and 11 PM to 12 AM transitions, where a wrong PM toggle or a misplaced day carry shows directly in the hours byte. The remaining tests cover the snapshot while a tick arrives, rounding above and below 30 seconds, a write that collides with a tick, and ticks while the clock is stopped; a design that mishandles any of these returns stale or advanced values, or raises events it should not.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned AW = 5;
  localparam int unsigned DW = 8;

  typedef logic [DW-1:0] bcd8_t;

  localparam logic [AW-1:0] A_SEC  = 5'h00;
  localparam logic [AW-1:0] A_MIN  = 5'h01;
  localparam logic [AW-1:0] A_HOUR = 5'h02;
  localparam logic [AW-1:0] A_DAY  = 5'h03;
  localparam logic [AW-1:0] A_MON  = 5'h04;
  localparam logic [AW-1:0] A_YEAR = 5'h05;
  localparam logic [AW-1:0] A_WDAY = 5'h06;
  localparam logic [AW-1:0] A_CTRL = 5'h0D;

  localparam int unsigned C_RUN   = 0;
  localparam int unsigned C_ROUND = 1;
  localparam int unsigned C_COMP  = 2;
  localparam int unsigned C_12H   = 3;
  localparam int unsigned C_SNAP  = 6;

  typedef struct packed {
    bcd8_t sec;
    bcd8_t min;
    bcd8_t hour;
    bcd8_t day;
    bcd8_t mon;
    bcd8_t year;
    bcd8_t wday;
  } tod_t;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    bcd8_t r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic is_leap(bcd8_t y);
    int unsigned b;
    b = int'(y[7:4]) * 10 + int'(y[3:0]);
    return (b % 4) == 0;
  endfunction

  function automatic bcd8_t month_len(bcd8_t m, bcd8_t y);
    bcd8_t r;
    case (m)
      8'h02:                      r = is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap #(
  parameter logic [7:0] MAX_V = 8'h59,
  parameter logic [7:0] MIN_V = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       inc_i,
  input  logic       clr_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  logic [7:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= MIN_V;
    else if (ld_i)   val_q <= ld_val_i;
    else if (clr_i)  val_q <= MIN_V;
    else if (inc_i)  val_q <= (val_q >= MAX_V) ? MIN_V : rtc_pkg::bcd_inc(val_q);
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i && (val_q >= MAX_V);
endmodule

// File: rtl/rtc_hour_cnt.sv
module rtc_hour_cnt (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode12_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  input  logic       inc_i,
  output logic [7:0] val_o,
  output logic       wrap_o
);
  logic [7:0] val_q, nxt_c, low_c, low_inc;
  logic       pm, wrap_c;

  assign pm      = val_q[7];
  assign low_c   = {3'b000, val_q[4:0]};
  assign low_inc = rtc_pkg::bcd_inc(low_c);

  always_comb begin
    wrap_c = 1'b0;
    if (mode12_i) begin
      if (low_c == 8'h12) begin
        nxt_c = {pm, 2'b00, 5'h01};
      end else if (low_c == 8'h11) begin
        nxt_c  = {~pm, 2'b00, 5'h12};
        wrap_c = pm;
      end else begin
        nxt_c = {pm, 2'b00, low_inc[4:0]};
      end
    end else begin
      if (val_q >= 8'h23) begin
        nxt_c  = 8'h00;
        wrap_c = 1'b1;
      end else begin
        nxt_c = rtc_pkg::bcd_inc(val_q);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= 8'h00;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= nxt_c;
  end

  assign val_o  = val_q;
  assign wrap_o = inc_i && wrap_c;
endmodule

// File: rtl/rtc_date_cnt.sv
module rtc_date_cnt #(
  parameter int unsigned NFLD = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NFLD-1:0] ld_i,       // day, month, year, weekday
  input  logic [7:0]      ld_val_i,
  input  logic            inc_i,
  output logic [7:0]      day_o,
  output logic [7:0]      mon_o,
  output logic [7:0]      year_o,
  output logic [7:0]      wday_o
);
  logic [7:0] day_q, mon_q, year_q, wday_q, last_c;

  assign last_c = rtc_pkg::month_len(mon_q, year_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      day_q  <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      wday_q <= 8'h00;
    end else begin
      if (inc_i) begin
        if (day_q >= last_c) begin
          day_q <= 8'h01;
          if (mon_q >= 8'h12) begin
            mon_q  <= 8'h01;
            year_q <= (year_q >= 8'h99) ? 8'h00 : rtc_pkg::bcd_inc(year_q);
          end else begin
            mon_q <= rtc_pkg::bcd_inc(mon_q);
          end
        end else begin
          day_q <= rtc_pkg::bcd_inc(day_q);
        end
        wday_q <= (wday_q >= 8'h06) ? 8'h00 : wday_q + 8'h01;
      end
      if (ld_i[0]) day_q  <= ld_val_i;
      if (ld_i[1]) mon_q  <= ld_val_i;
      if (ld_i[2]) year_q <= ld_val_i;
      if (ld_i[3]) wday_q <= ld_val_i;
    end
  end

  assign day_o  = day_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;
  assign wday_o = wday_q;
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int unsigned NTIME = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_1hz_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sec_evt_o,
  output logic          min_evt_o,
  output logic          hour_evt_o,
  output logic          day_evt_o
);
  localparam int unsigned NEVT = 4;

  logic run_q, round_q, comp_q, m12_q, snap_q;
  tod_t live, snap_tod_q, view;
  logic [NTIME-1:0] ld;
  logic time_wr, ctrl_wr, adv, rnd;
  logic sec_wrap, sec_carry, min_wrap, hour_wrap;
  logic [NEVT-1:0] evt_q;
  logic [DW-1:0] ctrl_rd;

  assign time_wr = we_i && (addr_i <= A_WDAY);
  assign ctrl_wr = we_i && (addr_i == A_CTRL);
  assign ld      = time_wr ? (NTIME'(1) << addr_i) : '0;
  assign adv     = run_q && tick_1hz_i && !time_wr;
  assign rnd     = adv && round_q;

  rtc_bcd_wrap #(.MAX_V(8'h59), .MIN_V(8'h00)) u_sec (
    .clk_i, .rst_ni, .ld_i(ld[0]), .ld_val_i(wdata_i),
    .inc_i(adv && !rnd), .clr_i(rnd), .val_o(live.sec), .wrap_o(sec_wrap)
  );

  assign sec_carry = sec_wrap || (rnd && (live.sec >= 8'h30));

  rtc_bcd_wrap #(.MAX_V(8'h59), .MIN_V(8'h00)) u_min (
    .clk_i, .rst_ni, .ld_i(ld[1]), .ld_val_i(wdata_i),
    .inc_i(sec_carry), .clr_i(1'b0), .val_o(live.min), .wrap_o(min_wrap)
  );

  rtc_hour_cnt u_hour (
    .clk_i, .rst_ni, .mode12_i(m12_q), .ld_i(ld[2]), .ld_val_i(wdata_i),
    .inc_i(min_wrap), .val_o(live.hour), .wrap_o(hour_wrap)
  );

  rtc_date_cnt #(.NFLD(NTIME-3)) u_date (
    .clk_i, .rst_ni, .ld_i(ld[NTIME-1:3]), .ld_val_i(wdata_i), .inc_i(hour_wrap),
    .day_o(live.day), .mon_o(live.mon), .year_o(live.year), .wday_o(live.wday)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      round_q    <= 1'b0;
      comp_q     <= 1'b0;
      m12_q      <= 1'b0;
      snap_q     <= 1'b0;
      snap_tod_q <= '0;
    end else if (ctrl_wr) begin
      run_q   <= wdata_i[C_RUN];
      round_q <= wdata_i[C_ROUND];
      comp_q  <= wdata_i[C_COMP];
      m12_q   <= wdata_i[C_12H];
      snap_q  <= wdata_i[C_SNAP];
      if (wdata_i[C_SNAP]) snap_tod_q <= live;
    end else if (rnd) begin
      round_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= '0;
    else         evt_q <= {hour_wrap, min_wrap, sec_carry, adv};
  end

  assign {day_evt_o, hour_evt_o, min_evt_o, sec_evt_o} = evt_q;

  assign view = snap_q ? snap_tod_q : live;

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[C_RUN]   = run_q;
    ctrl_rd[C_ROUND] = round_q;
    ctrl_rd[C_COMP]  = comp_q;
    ctrl_rd[C_12H]   = m12_q;
    ctrl_rd[C_SNAP]  = snap_q;
  end

  always_comb begin
    case (addr_i)
      A_SEC:   rdata_o = view.sec;
      A_MIN:   rdata_o = view.min;
      A_HOUR:  rdata_o = view.hour;
      A_DAY:   rdata_o = view.day;
      A_MON:   rdata_o = view.mon;
      A_YEAR:  rdata_o = view.year;
      A_WDAY:  rdata_o = view.wday;
      A_CTRL:  rdata_o = ctrl_rd;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_1hz_i,
  input logic               run_q,
  input logic               snap_q,
  input logic               ctrl_wr,
  input logic               time_wr,
  input logic [3:0]         evt_i,
  input logic [7:0]         wday_i,
  input rtc_pkg::tod_t      snap_i
);
  p_min_needs_sec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[1] |-> evt_i[0]);
  p_hour_needs_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[2] |-> evt_i[1]);
  p_day_needs_hour_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[3] |-> evt_i[2]);
  p_stopped_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |=> !evt_i[0]);
  p_evt_from_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_1hz_i |=> !evt_i[0]);
  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_wr |=> !evt_i[0]);
  p_wday_moves_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[3] |-> wday_i != $past(wday_i));
  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snap_q && !ctrl_wr) |=> $stable(snap_i));
endmodule

bind rtc_bcd_calendar rtc_calendar_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_1hz_i(tick_1hz_i),
  .run_q(run_q), .snap_q(snap_q), .ctrl_wr(ctrl_wr), .time_wr(time_wr),
  .evt_i({day_evt_o, hour_evt_o, min_evt_o, sec_evt_o}),
  .wday_i(live.wday), .snap_i(snap_tod_q)
);

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sec_evt, min_evt, hour_evt, day_evt;
  logic [3:0] ev, ev_next;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rtc_bcd_calendar u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sec_evt_o(sec_evt), .min_evt_o(min_evt),
    .hour_evt_o(hour_evt), .day_evt_o(day_evt)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic tick1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    ev = {day_evt, hour_evt, min_evt, sec_evt};
    @(negedge clk);
    ev_next = {day_evt, hour_evt, min_evt, sec_evt};
  endtask

  task automatic set_tod(input logic [7:0] s, m, h, d, mo, y, w);
    wr(5'h00, s); wr(5'h01, m); wr(5'h02, h); wr(5'h03, d);
    wr(5'h04, mo); wr(5'h05, y); wr(5'h06, w);
  endtask

  task automatic t_reset;
    rd_chk("R1 sec", 5'h00, 8'h00);
    rd_chk("R1 min", 5'h01, 8'h00);
    rd_chk("R1 hour", 5'h02, 8'h00);
    rd_chk("R1 day", 5'h03, 8'h01);
    rd_chk("R1 mon", 5'h04, 8'h01);
    rd_chk("R1 year", 5'h05, 8'h00);
    rd_chk("R1 wday", 5'h06, 8'h00);
    rd_chk("R1 ctrl", 5'h0D, 8'h00);
    chk("R1 events", {4'h0, day_evt, hour_evt, min_evt, sec_evt}, 8'h00);
    rd_chk("R2 unmapped", 5'h0A, 8'h00);
  endtask

  task automatic t_stopped;
    tick1;
    rd_chk("R3 stopped sec", 5'h00, 8'h00);
    chk("R3 stopped evt", {4'h0, ev}, 8'h00);
    wr(5'h00, 8'h40);
    tick1;
    rd_chk("R11 held while stopped", 5'h00, 8'h40);
    wr(5'h0D, 8'h01);
    tick1;
    rd_chk("R11 resume", 5'h00, 8'h41);
    chk("R3 sec_evt", {4'h0, ev}, 8'h01);
    chk("R12 pulse width", {4'h0, ev_next}, 8'h00);
  endtask

  task automatic t_count;
    wr(5'h00, 8'h07);
    rd_chk("R2 sec readback", 5'h00, 8'h07);
    tick1;
    tick1;
    tick1;
    rd_chk("R3 bcd count", 5'h00, 8'h10);
    chk("R3 evt", {4'h0, ev}, 8'h01);
  endtask

  task automatic t_full_wrap;
    set_tod(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h06);
    tick1;
    chk("R4 all events", {4'h0, ev}, 8'h0F);
    chk("R12 all drop", {4'h0, ev_next}, 8'h00);
    rd_chk("R4 sec", 5'h00, 8'h00);
    rd_chk("R4 min", 5'h01, 8'h00);
    rd_chk("R4 hour", 5'h02, 8'h00);
    rd_chk("R6 day", 5'h03, 8'h01);
    rd_chk("R6 mon", 5'h04, 8'h01);
    rd_chk("R6 year", 5'h05, 8'h00);
    rd_chk("R8 wday wrap", 5'h06, 8'h00);
  endtask

  task automatic day_edge(input logic [7:0] d, mo, y);
    set_tod(8'h59, 8'h59, 8'h23, d, mo, y, 8'h02);
    tick1;
  endtask

  task automatic t_month_len;
    day_edge(8'h30, 8'h04, 8'h05);
    rd_chk("R6 30-day day", 5'h03, 8'h01);
    rd_chk("R6 30-day mon", 5'h04, 8'h05);
    rd_chk("R8 wday step", 5'h06, 8'h03);
    day_edge(8'h30, 8'h05, 8'h05);
    rd_chk("R6 31-day no wrap", 5'h03, 8'h31);
    day_edge(8'h28, 8'h02, 8'h24);
    rd_chk("R7 leap 24 day", 5'h03, 8'h29);
    day_edge(8'h28, 8'h02, 8'h23);
    rd_chk("R7 plain 23 day", 5'h03, 8'h01);
    rd_chk("R7 plain 23 mon", 5'h04, 8'h03);
    day_edge(8'h29, 8'h02, 8'h00);
    rd_chk("R7 leap 00 mon", 5'h04, 8'h03);
    day_edge(8'h31, 8'h12, 8'h19);
    rd_chk("R6 year bcd step", 5'h05, 8'h20);
  endtask

  task automatic t_12h;
    wr(5'h0D, 8'h09);
    set_tod(8'h59, 8'h59, 8'h11, 8'h05, 8'h03, 8'h10, 8'h04);
    tick1;
    rd_chk("R5 11am to 12pm", 5'h02, 8'h92);
    chk("R5 no day evt", {4'h0, ev}, 8'h07);
    wr(5'h00, 8'h59); wr(5'h01, 8'h59);
    tick1;
    rd_chk("R5 12pm to 1pm", 5'h02, 8'h81);
    wr(5'h00, 8'h59); wr(5'h01, 8'h59); wr(5'h02, 8'h91);
    tick1;
    rd_chk("R5 11pm to 12am", 5'h02, 8'h12);
    chk("R5 day evt", {4'h0, ev}, 8'h0F);
    rd_chk("R5 day advanced", 5'h03, 8'h06);
    rd_chk("R8 wday", 5'h06, 8'h05);
    wr(5'h0D, 8'h01);
  endtask

  task automatic t_snapshot;
    wr(5'h00, 8'h10);
    wr(5'h0D, 8'h41);
    tick1;
    rd_chk("R9 frozen sec", 5'h00, 8'h10);
    rd_chk("R9 ctrl snap bit", 5'h0D, 8'h41);
    wr(5'h0D, 8'h01);
    rd_chk("R9 live sec", 5'h00, 8'h11);
  endtask

  task automatic t_round;
    wr(5'h00, 8'h45); wr(5'h01, 8'h05);
    wr(5'h0D, 8'h07);
    tick1;
    rd_chk("R10 up sec", 5'h00, 8'h00);
    rd_chk("R10 up min", 5'h01, 8'h06);
    chk("R10 up evt", {4'h0, ev}, 8'h03);
    rd_chk("R10 self clear", 5'h0D, 8'h05);
    wr(5'h00, 8'h20);
    wr(5'h0D, 8'h03);
    tick1;
    rd_chk("R10 down sec", 5'h00, 8'h00);
    rd_chk("R10 down min", 5'h01, 8'h06);
    chk("R10 down evt", {4'h0, ev}, 8'h01);
  endtask

  task automatic t_collide;
    @(negedge clk);
    we = 1'b1; addr = 5'h00; wdata = 8'h33; tick = 1'b1;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    chk("R11 no evt", {7'h0, sec_evt}, 8'h00);
    rd_chk("R11 write wins", 5'h00, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_stopped;
    t_count;
    t_full_wrap;
    t_month_len;
    t_12h;
    t_snapshot;
    t_round;
    t_collide;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog all requirements got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule